// File: doc/BRIEF.md
# Reset Supervisor with Fault Cause Latch

This block turns two digitised under-voltage indicators and a watchdog expiry pulse into a system reset. The reset output comes in two polarities. When either supply flag is raised, reset asserts at once. Once both flags have cleared, reset stays asserted for a programmable hold time and then releases. A watchdog expiry also asserts reset and holds it for the same hold time.

The hold time is one of four millisecond values, selected by a 2-bit code. The block converts it to clock cycles through a cycles-per-millisecond parameter, so a simulation can run with a very small clock-rate figure.

Every reset cause is recorded in an 8-bit cause register that software reads and clears through a small byte-addressed register port. The causes are a low first supply, a low second supply and a watchdog expiry. The cause register keeps its bits until it is overwritten directly or the whole block is reset. The synchronous reset input `rst` stands for a full power cycle.

Top module: `rstsup_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sys_rst` is 1, `sys_rst_n` is 0 and the cause register reads 0x00. `rst` also returns the delay code to 01.
- R2: When `v1_low` or `v2_low` is sampled high, `sys_rst` is 1 from the next cycle on. It stays 1 for as long as either flag stays high.
- R3: After the last cycle in which a supply flag or the watchdog pulse was sampled high, `sys_rst` stays 1 for exactly HOLD cycles and is 0 after them. HOLD = delay_ms × CYC_PER_MS. A new trip before the end restarts the count from zero. `sys_rst_n` is always the inverse of `sys_rst`.
- R4: The delay code maps 00→50 ms, 01→200 ms, 10→400 ms and 11→800 ms. The code is 01 after `rst`. A new code is taken from `dly_sel` on a cycle in which `dly_upd` is high.
- R5: A one-cycle `wd_expire` pulse sets `sys_rst` on the next cycle and holds it for HOLD cycles. It also sets cause bit 4.
- R6: The cause register is 8 bits wide. Bit 7 is set by `v1_low`, bit 6 by `v2_low` and bit 4 by `wd_expire`. All other bits read 0. A set bit stays set until it is written or `rst` is applied.
- R7: A write is accepted at address 0xFF with no enable step beforehand. The register then takes data bits 7, 6 and 4. If a cause event and a write hit the same bit in the same cycle, the event wins and the bit ends up set.
- R8: Within one `reg_cs` frame, only the first write strobe is accepted. Later strobes in the same frame are ignored. Writes to any other address are ignored, and reads from any other address return 0x00. `reg_rdata` is registered: it shows the register value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, equivalent to a power cycle |
| v1_low | input | 1 | First supply below threshold (synchronous) |
| v2_low | input | 1 | Second supply below threshold (synchronous) |
| wd_expire | input | 1 | Watchdog expiry pulse |
| dly_sel | input | 2 | Hold-time code to load |
| dly_upd | input | 1 | Load strobe for `dly_sel` |
| reg_cs | input | 1 | Register transaction frame |
| reg_addr | input | 8 | Byte address |
| reg_wr | input | 1 | Write strobe, one per data byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench measures the release edge to the exact cycle for all four delay codes and for the code restored after `rst`. A counter that is off by one, or a code table that is swapped, therefore moves the release by a whole cycle or by hundreds of cycles. A trip in the middle of a hold period must restart the count. A design that only resumes the count would release early.

On the register side, the bench sends a second byte in one frame and writes to a foreign address. Either of these would corrupt the latched causes in a design that skipped the one-byte rule or the address decode. The bench also collides a write of zero with a live supply event. A design that gives the write priority would lose the cause of the reset in progress.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef enum logic [1:0] {
    DLY_50  = 2'b00,
    DLY_200 = 2'b01,
    DLY_400 = 2'b10,
    DLY_800 = 2'b11
  } dly_code_e;

  localparam logic [7:0] CAUSE_ADDR = 8'hFF;
  localparam int         NCAUSE     = 3;
  localparam int         MAX_MS     = 800;

  // bit position of cause index 0 (V1), 1 (V2), 2 (watchdog)
  function automatic int cause_pos(input int idx);
    case (idx)
      0:       return 7;
      1:       return 6;
      default: return 4;
    endcase
  endfunction

  function automatic int unsigned code_ms(input dly_code_e c);
    case (c)
      DLY_50:  return 50;
      DLY_200: return 200;
      DLY_400: return 400;
      default: return 800;
    endcase
  endfunction

endpackage

// File: rtl/rstsup_hold.sv
module rstsup_hold
  import rstsup_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  localparam int CNT_W = $clog2(MAX_MS * CYC_PER_MS + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      trip,
  input  dly_code_e code,
  output logic      active
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb last = CNT_W'(code_ms(code) * CYC_PER_MS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (trip) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (cnt >= last) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: no release while a hold period is still incomplete
  a_r3_no_early_release: assert property (@(posedge clk) disable iff (rst)
    (active && !trip && cnt < last) |=> active);

  // R3: release happens only after the final count
  a_r3_release_at_end: assert property (@(posedge clk) disable iff (rst)
    (active && !trip && cnt >= last) |=> !active);

  // R2/R5: any trip forces the hold state next cycle
  a_r2_trip_holds: assert property (@(posedge clk) disable iff (rst)
    trip |=> (active && cnt == '0));

endmodule

// File: rtl/rstsup_cause.sv
module rstsup_cause
  import rstsup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] ev,
  input  logic              cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic              seen;
  logic              wr_ok;
  logic [DATA_W-1:0] cause_vec;

  assign wr_ok = cs && wr && !seen && (addr == ADDR_W'(CAUSE_ADDR));

  always_ff @(posedge clk) begin
    if (rst)      seen <= 1'b0;
    else if (!cs) seen <= 1'b0;
    else if (wr)  seen <= 1'b1;
  end

  always_comb begin
    cause_vec = '0;
    for (int i = 0; i < NCAUSE; i++) cause_vec[cause_pos(i)] = flag_q[i];
  end

  logic [NCAUSE-1:0] flag_q;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_flag
    localparam int P = cause_pos(g);
    always_ff @(posedge clk) begin
      if (rst)        flag_q[g] <= 1'b0;
      else if (ev[g]) flag_q[g] <= 1'b1;
      else if (wr_ok) flag_q[g] <= wdata[P];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= (addr == ADDR_W'(CAUSE_ADDR)) ? cause_vec : '0;
  end

  // R6: an event always leaves its bit set
  a_r6_event_sets: assert property (@(posedge clk) disable iff (rst)
    ev[0] |=> cause_vec[7]);

  // R6: a set bit survives when no write is accepted
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (cause_vec[6] && !wr_ok) |=> cause_vec[6]);

  // R8: a second byte in the same frame changes nothing
  a_r8_one_byte: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && seen && ev == '0) |=> $stable(cause_vec));

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v1_low,
  input  logic              v2_low,
  input  logic              wd_expire,
  input  logic [1:0]        dly_sel,
  input  logic              dly_upd,
  input  logic              reg_cs,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_rst,
  output logic              sys_rst_n
);

  dly_code_e code_q;
  logic      hold;

  always_ff @(posedge clk) begin
    if (rst)          code_q <= DLY_200;
    else if (dly_upd) code_q <= dly_code_e'(dly_sel);
  end

  rstsup_hold #(.CYC_PER_MS(CYC_PER_MS)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .trip   (v1_low | v2_low | wd_expire),
    .code   (code_q),
    .active (hold)
  );

  rstsup_cause #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cause (
    .clk   (clk),
    .rst   (rst),
    .ev    ({wd_expire, v2_low, v1_low}),
    .cs    (reg_cs),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata)
  );

  assign sys_rst   = hold;
  assign sys_rst_n = ~hold;

  // R2: a low supply flag yields reset on the next cycle
  a_r2_supply_trip: assert property (@(posedge clk) disable iff (rst)
    (v1_low || v2_low) |=> sys_rst);

  // R5: a watchdog pulse yields reset on the next cycle
  a_r5_wd_trip: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> sys_rst);

endmodule

// File: tb/sim_rstsup_top.sv
module sim_rstsup_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 2;

  logic       clk = 1'b0;
  logic       rst, v1_low, v2_low, wd_expire, dly_upd, reg_cs, reg_wr;
  logic [1:0] dly_sel;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sys_rst, sys_rst_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstsup_top #(.CYC_PER_MS(CPM)) u0 (
    .clk(clk), .rst(rst), .v1_low(v1_low), .v2_low(v2_low),
    .wd_expire(wd_expire), .dly_sel(dly_sel), .dly_upd(dly_upd),
    .reg_cs(reg_cs), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst(sys_rst), .sys_rst_n(sys_rst_n));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_cause(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    cyc(2);
    d = reg_rdata;
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [7:0] d0,
                          input bit two, input logic [7:0] d1);
    reg_cs = 1'b1; reg_addr = a; reg_wdata = d0; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
    if (two) begin
      reg_wdata = d1; reg_wr = 1'b1;
      cyc(1);
      reg_wr = 1'b0;
    end
    reg_cs = 1'b0;
    cyc(1);
  endtask

  // stimulus has just been removed at a negedge; measure the release
  task automatic expect_release(input string tag, input int hold);
    cyc(hold - 1);
    chk({tag, " still held"}, sys_rst, 1);
    cyc(1);
    chk({tag, " released"}, sys_rst, 0);
    chk({tag, " inverse output"}, sys_rst_n, 1);
  endtask

  task automatic load_code(input logic [1:0] c);
    dly_sel = c; dly_upd = 1'b1;
    cyc(1);
    dly_upd = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rst = 1'b1;
    cyc(3);
    chk("R1 sys_rst in reset", sys_rst, 1);
    chk("R1 sys_rst_n in reset", sys_rst_n, 0);
    rd_cause(8'hFF, d);
    chk("R1 cause cleared", d, 8'h00);
    rst = 1'b0;
    expect_release("R4 default code 01 (R3)", 200 * CPM);
  endtask

  task automatic t_supply_restart();
    logic [7:0] d;
    v1_low = 1'b1;
    cyc(1);
    chk("R2 v1 trips reset", sys_rst, 1);
    cyc(5);
    chk("R2 held while flag high", sys_rst, 1);
    v1_low = 1'b0;
    cyc(50);
    v2_low = 1'b1;
    cyc(1);
    v2_low = 1'b0;
    expect_release("R3 restart after mid-count trip", 200 * CPM);
    rd_cause(8'hFF, d);
    chk("R6 v1 and v2 causes", d, 8'hC0);
  endtask

  task automatic t_writes();
    logic [7:0] d;
    wr_frame(8'hFF, 8'h00, 1'b0, 8'h00);
    rd_cause(8'hFF, d);
    chk("R7 direct write clears", d, 8'h00);
    wr_frame(8'hFF, 8'hFF, 1'b0, 8'h00);
    rd_cause(8'hFF, d);
    chk("R7 write keeps only bits 7,6,4", d, 8'hD0);
    wr_frame(8'hFF, 8'h10, 1'b1, 8'hFF);
    rd_cause(8'hFF, d);
    chk("R8 second byte rejected", d, 8'h10);
    wr_frame(8'h20, 8'h00, 1'b0, 8'h00);
    rd_cause(8'hFF, d);
    chk("R8 foreign address write ignored", d, 8'h10);
    rd_cause(8'h20, d);
    chk("R8 foreign address reads zero", d, 8'h00);
  endtask

  task automatic t_watchdog();
    logic [7:0] d;
    wr_frame(8'hFF, 8'h00, 1'b0, 8'h00);
    load_code(2'b00);
    wd_expire = 1'b1;
    cyc(1);
    wd_expire = 1'b0;
    chk("R5 watchdog trips reset", sys_rst, 1);
    expect_release("R4 code 00 50ms (R5)", 50 * CPM);
    rd_cause(8'hFF, d);
    chk("R5 watchdog cause bit 4", d, 8'h10);
  endtask

  task automatic t_codes();
    load_code(2'b10);
    v1_low = 1'b1;
    cyc(1);
    v1_low = 1'b0;
    expect_release("R4 code 10 400ms", 400 * CPM);
    load_code(2'b11);
    wd_expire = 1'b1;
    cyc(1);
    wd_expire = 1'b0;
    expect_release("R4 code 11 800ms", 800 * CPM);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr_frame(8'hFF, 8'h00, 1'b0, 8'h00);
    v2_low = 1'b1;
    wr_frame(8'hFF, 8'h00, 1'b0, 8'h00);
    v2_low = 1'b0;
    rd_cause(8'hFF, d);
    chk("R7 event beats write", d, 8'h40);
  endtask

  task automatic t_power_cycle();
    logic [7:0] d;
    rst = 1'b1;
    cyc(2);
    rd_cause(8'hFF, d);
    chk("R1 power cycle clears cause", d, 8'h00);
    rst = 1'b0;
    expect_release("R1 code restored to 01 (R4)", 200 * CPM);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; v1_low = 1'b0; v2_low = 1'b0; wd_expire = 1'b0;
    dly_sel = 2'b00; dly_upd = 1'b0; reg_cs = 1'b0; reg_addr = 8'h00;
    reg_wr = 1'b0; reg_wdata = 8'h00;
    @(negedge clk);
    t_reset_state();
    t_supply_restart();
    t_writes();
    t_watchdog();
    t_codes();
    t_collision();
    t_power_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule